// File: doc/BRIEF.md
# Dual-SAR-ADC acquisition sequencer

This block runs an external converter that holds two 12-bit successive-approximation ADCs. Both ADCs sample at the same instant and each returns its result on its own serial data line. A client hands the sequencer a conversion request through a valid/ready handshake. The request names a 3-bit input address, single-ended or differential operation, the input span (one or two times the reference) and whether a two's complement result should be returned as offset binary. The sequencer drives the converter's control lines from the request. It waits a programmable acquisition interval and then runs one chip-select frame. During that frame it shifts in both data lines in parallel.

Each control line has its own window of required stability, counted in serial-clock edges. The sequencer takes a new request only once the track-and-hold has gone back to tracking, which happens at the 14th rising serial-clock edge of a frame. Any change to a control line restarts the acquisition interval. The sequencer also keeps a record of the frame's configuration. From that record it marks each result pair as two's complement or straight binary. In the differential case this depends on whether the pair is fully or pseudo-differential, which address bit 0 selects.

Top module: `dual_sar_sequencer`

## Requirements
- R1: After reset, `adc_cs_n` and `adc_sclk` are high, `adc_addr`, `adc_single` and `adc_wide` are 0, `res_valid` is low and `req_ready` is high.
- R2: A frame holds `adc_cs_n` low for exactly 16 `adc_sclk` periods. Each high or low phase of `adc_sclk` lasts SCLK_HALF system clocks, and the first falling edge comes SCLK_HALF clocks after `adc_cs_n` falls. `adc_sclk` is high whenever `adc_cs_n` is high, and `adc_cs_n` rises together with the 16th rising edge.
- R3: Both data lines are sampled on rising `adc_sclk` edges. Rising edges 1, 2, 15 and 16 are ignored. Edges 3 to 14 give result bits 11 down to 0, MSB first.
- R4: `res_valid` is a single-cycle pulse. It appears in the cycle in which the 14th rising edge shows on `adc_sclk`, and there is one pulse per accepted request, in acceptance order.
- R5: When a request is accepted, the cycle that follows drives `adc_addr` = `req_addr`, `adc_single` = `req_single` (1 = single-ended) and `adc_wide` = `req_wide` (1 = twice-reference span). These levels hold until the next acceptance.
- R6: `adc_addr`, `adc_single` and `adc_wide` do not change from the fall of `adc_cs_n` through the 14th rising edge of that frame.
- R7: `req_ready` is low from the fall of `adc_cs_n` until the 14th rising edge. It is also low while an accepted request waits for its frame.
- R8: `adc_cs_n` falls in the cycle given by the latest of three bounds: ACQ_CYCLES+1 cycles after the most recent restart, two cycles after the latest acceptance, and one cycle after the previous frame's end. A restart is a cycle in which a control line shows a new level, or the cycle of a 14th rising edge.
- R9: `res_twos` is 1 when `adc_wide` = 1 for that frame, or when the frame was differential (`adc_single` = 0) with `adc_addr[0]` = 0 (fully differential). Otherwise it is 0 and the words are straight binary.
- R10: When the frame's coding is two's complement and `req_offset` was 1, bit 11 of both words is inverted and `res_twos` is 0. For straight binary frames, `req_offset` has no effect on the words.
- R11: A request accepted during a frame with the same three control levels does not restart the acquisition interval. Its frame starts ACQ_CYCLES+1 cycles after the previous 14th rising edge, or one cycle after that frame ends if that is later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Conversion request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_addr | input | 3 | Input multiplexer address |
| req_single | input | 1 | 1 = single-ended, 0 = differential |
| req_wide | input | 1 | 1 = twice-reference span, 0 = reference span |
| req_offset | input | 1 | Return two's complement results as offset binary |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_sclk | output | 1 | Converter serial clock, idles high |
| adc_addr | output | 3 | Converter multiplexer address |
| adc_single | output | 1 | Converter single-ended/differential select |
| adc_wide | output | 1 | Converter span select |
| adc_dout_a | input | 1 | Serial data from converter A |
| adc_dout_b | input | 1 | Serial data from converter B |
| res_valid | output | 1 | Result pair valid pulse |
| res_word_a | output | 12 | Result of converter A |
| res_word_b | output | 12 | Result of converter B |
| res_twos | output | 1 | 1 = words are two's complement, 0 = unsigned |

## Verification
An edge counter that slips by one shifts every result by a bit, which shows up in the first result pair of the frame. It also moves the `res_valid` pulse and the `req_ready` release away from the 14th rising edge on `adc_sclk`. A wrong acquisition counter or restart decision moves the fall of `adc_cs_n` away from the cycle predicted from line changes, acceptances and frame ends, so it shows at the very next frame. A stale frame configuration gives a wrong `res_twos` or a wrong MSB in the same pulse. Random requests mix single-ended, fully and pseudo-differential frames, both spans and the offset option. Directed cases cover extreme data words and a repeated request with unchanged lines.

// File: rtl/dsq_pkg.sv
package dsq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ACQ   = 2'd1,
        ST_FRAME = 2'd2
    } seq_state_e;

    // Two's complement unless the input is referred to ground (single-ended
    // or pseudo-differential) and the narrow span is selected.
    function automatic logic coding_is_twos(input logic single,
                                            input logic addr0,
                                            input logic wide);
        return wide || (!single && !addr0);
    endfunction

endpackage

// File: rtl/dsq_divider.sv
module dsq_divider #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        tick  = 1'b0;
        if (!run) begin
            cnt_d = '0;
        end else if (cnt_q == CW'(HALF - 1)) begin
            cnt_d = '0;
            tick  = 1'b1;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/dsq_capture.sv
module dsq_capture #(
    parameter int NCONV = 2,
    parameter int W     = 12
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      shift_en,
    input  logic [NCONV-1:0]          din,
    output logic [NCONV-1:0][W-1:0]   word
);
    for (genvar g = 0; g < NCONV; g++) begin : g_lane
        logic [W-1:0] sh_q, sh_d;

        always_comb begin
            sh_d = sh_q;
            if (shift_en) sh_d = {sh_q[W-2:0], din[g]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= sh_d;
        end

        assign word[g] = sh_q;
    end
endmodule

// File: rtl/dsq_coding.sv
module dsq_coding #(
    parameter int W = 12
) (
    input  logic [W-1:0] raw,
    input  logic         twos,
    input  logic         to_offset,
    output logic [W-1:0] word
);
    logic flip;

    always_comb begin
        flip = twos && to_offset;
        word = raw ^ {flip, {(W-1){1'b0}}};
    end
endmodule

// File: rtl/dual_sar_sequencer.sv
module dual_sar_sequencer
    import dsq_pkg::*;
#(
    parameter int DATA_W     = 12,
    parameter int LEAD_BITS  = 2,
    parameter int TAIL_BITS  = 2,
    parameter int SCLK_HALF  = 2,
    parameter int ACQ_CYCLES = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [2:0]        req_addr,
    input  logic              req_single,
    input  logic              req_wide,
    input  logic              req_offset,
    output logic              adc_cs_n,
    output logic              adc_sclk,
    output logic [2:0]        adc_addr,
    output logic              adc_single,
    output logic              adc_wide,
    input  logic              adc_dout_a,
    input  logic              adc_dout_b,
    output logic              res_valid,
    output logic [DATA_W-1:0] res_word_a,
    output logic [DATA_W-1:0] res_word_b,
    output logic              res_twos
);
    localparam int NCONV      = 2;
    localparam int TRACK_EDGE = LEAD_BITS + DATA_W;
    localparam int FRAME_LEN  = TRACK_EDGE + TAIL_BITS;
    localparam int EW         = $clog2(FRAME_LEN + 1);
    localparam int AW         = $clog2(ACQ_CYCLES + 1);

    typedef struct packed {
        seq_state_e    st;
        logic          cs_n;
        logic          sclk;
        logic [EW-1:0] edges;
        logic [AW-1:0] acq;
        logic [2:0]    addr;
        logic          single;
        logic          wide;
        logic          offset;
        logic          pend;
        logic          track;
        logic          f_single;
        logic          f_addr0;
        logic          f_wide;
        logic          f_offset;
        logic          res_valid;
    } regs_t;

    regs_t q, d;

    logic                          tick;
    logic                          rise_evt;
    logic [EW-1:0]                 edge_nx;
    logic                          shift_en;
    logic                          accept;
    logic                          lines_chg;
    logic                          frame_twos;
    logic [NCONV-1:0]              din;
    logic [NCONV-1:0][DATA_W-1:0]  raw_w;
    logic [NCONV-1:0][DATA_W-1:0]  out_w;

    dsq_divider #(.HALF(SCLK_HALF)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (q.st == ST_FRAME),
        .tick  (tick)
    );

    assign din = {adc_dout_b, adc_dout_a};

    dsq_capture #(.NCONV(NCONV), .W(DATA_W)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .din      (din),
        .word     (raw_w)
    );

    assign frame_twos = coding_is_twos(q.f_single, q.f_addr0, q.f_wide);

    for (genvar g = 0; g < NCONV; g++) begin : g_code
        dsq_coding #(.W(DATA_W)) u_code (
            .raw       (raw_w[g]),
            .twos      (frame_twos),
            .to_offset (q.f_offset),
            .word      (out_w[g])
        );
    end

    always_comb begin
        d = q;
        d.res_valid = 1'b0;

        req_ready = (q.st == ST_IDLE) || (q.st == ST_FRAME && q.track && !q.pend);
        accept    = req_valid && req_ready;
        lines_chg = accept &&
                    ({req_addr, req_single, req_wide} != {q.addr, q.single, q.wide});

        rise_evt = (q.st == ST_FRAME) && tick && !q.sclk;
        edge_nx  = q.edges + 1'b1;
        shift_en = rise_evt && (edge_nx > EW'(LEAD_BITS)) && (edge_nx <= EW'(TRACK_EDGE));

        if (q.acq != AW'(ACQ_CYCLES)) d.acq = q.acq + 1'b1;

        if (accept) begin
            d.addr   = req_addr;
            d.single = req_single;
            d.wide   = req_wide;
            d.offset = req_offset;
            if (lines_chg) d.acq = '0;
            if (q.st == ST_IDLE) d.st = ST_ACQ;
            else                 d.pend = 1'b1;
        end

        case (q.st)
            ST_ACQ: begin
                if (q.acq == AW'(ACQ_CYCLES)) begin
                    d.st       = ST_FRAME;
                    d.cs_n     = 1'b0;
                    d.sclk     = 1'b1;
                    d.edges    = '0;
                    d.track    = 1'b0;
                    d.f_single = q.single;
                    d.f_addr0  = q.addr[0];
                    d.f_wide   = q.wide;
                    d.f_offset = q.offset;
                end
            end
            ST_FRAME: begin
                if (tick) begin
                    d.sclk = !q.sclk;
                    if (!q.sclk) begin
                        d.edges = edge_nx;
                        if (edge_nx == EW'(TRACK_EDGE)) begin
                            d.track     = 1'b1;
                            d.acq       = '0;
                            d.res_valid = 1'b1;
                        end
                        if (edge_nx == EW'(FRAME_LEN)) begin
                            d.cs_n = 1'b1;
                            d.st   = (q.pend || accept) ? ST_ACQ : ST_IDLE;
                            d.pend = 1'b0;
                        end
                    end
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.cs_n <= 1'b1;
            q.sclk <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign adc_cs_n   = q.cs_n;
    assign adc_sclk   = q.sclk;
    assign adc_addr   = q.addr;
    assign adc_single = q.single;
    assign adc_wide   = q.wide;
    assign res_valid  = q.res_valid;
    assign res_word_a = out_w[0];
    assign res_word_b = out_w[1];
    assign res_twos   = frame_twos && !q.f_offset;

endmodule

// File: rtl/dsq_checker.sv
module dsq_checker #(
    parameter int ACQ_CYCLES = 20,
    parameter int TRACK_EDGE = 14
) (
    input logic       clk,
    input logic       rst_n,
    input logic       adc_cs_n,
    input logic       adc_sclk,
    input logic [2:0] adc_addr,
    input logic       adc_single,
    input logic       adc_wide,
    input logic       req_ready,
    input logic       res_valid
);
    localparam int RW = $clog2(TRACK_EDGE + 1) + 1;
    localparam int QW = $clog2(ACQ_CYCLES + 1) + 1;

    logic          sclk_prev_q;
    logic [4:0]    lines_prev_q;
    logic [RW-1:0] rises_q;
    logic [QW-1:0] quiet_q;
    logic          rise_now;
    logic [RW-1:0] rises_now;
    logic          restart_now;
    logic [4:0]    lines;

    always_comb begin
        lines       = {adc_addr, adc_single, adc_wide};
        rise_now    = adc_sclk && !sclk_prev_q && !adc_cs_n;
        rises_now   = rises_q + RW'(rise_now);
        restart_now = (lines != lines_prev_q) ||
                      (rise_now && rises_q == RW'(TRACK_EDGE - 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_prev_q  <= 1'b1;
            lines_prev_q <= '0;
            rises_q      <= '0;
            quiet_q      <= '0;
        end else begin
            sclk_prev_q  <= adc_sclk;
            lines_prev_q <= lines;
            if (adc_cs_n)                            rises_q <= '0;
            else if (rise_now && rises_q != RW'(TRACK_EDGE)) rises_q <= rises_q + 1'b1;
            if (restart_now)                         quiet_q <= '0;
            else if (quiet_q < QW'(ACQ_CYCLES))      quiet_q <= quiet_q + 1'b1;
        end
    end

    a_r2_sclk_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        adc_cs_n |-> adc_sclk);

    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    a_r6_lines_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!adc_cs_n && rises_now < RW'(TRACK_EDGE)) |-> $stable(lines));

    a_r7_ready_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!adc_cs_n && rises_now < RW'(TRACK_EDGE)) |-> !req_ready);

    a_r8_acq_elapsed: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_cs_n) |-> (quiet_q >= QW'(ACQ_CYCLES)));

endmodule

bind dual_sar_sequencer dsq_checker #(
    .ACQ_CYCLES (ACQ_CYCLES),
    .TRACK_EDGE (LEAD_BITS + DATA_W)
) u_dsq_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .adc_cs_n   (adc_cs_n),
    .adc_sclk   (adc_sclk),
    .adc_addr   (adc_addr),
    .adc_single (adc_single),
    .adc_wide   (adc_wide),
    .req_ready  (req_ready),
    .res_valid  (res_valid)
);

// File: tb/dual_sar_sequencer_test.sv
module dual_sar_sequencer_test;
    localparam int DIV   = 2;
    localparam int ACQ   = 20;
    localparam int W     = 12;
    localparam int TRACK = 14;
    localparam int FRAME = 16;

    typedef struct {
        logic [2:0] addr;
        logic       single;
        logic       wide;
        logic       off;
    } req_t;

    typedef struct {
        req_t         r;
        logic [W-1:0] a;
        logic [W-1:0] b;
    } res_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [2:0] req_addr = '0;
    logic req_single = 1'b0, req_wide = 1'b0, req_offset = 1'b0;
    logic adc_cs_n, adc_sclk, adc_single, adc_wide;
    logic [2:0] adc_addr;
    logic adc_dout_a = 1'b0, adc_dout_b = 1'b0;
    logic res_valid, res_twos;
    logic [W-1:0] res_word_a, res_word_b;

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;

    dual_sar_sequencer #(.DATA_W(W), .SCLK_HALF(DIV), .ACQ_CYCLES(ACQ)) uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_single(req_single), .req_wide(req_wide),
        .req_offset(req_offset),
        .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk), .adc_addr(adc_addr),
        .adc_single(adc_single), .adc_wide(adc_wide),
        .adc_dout_a(adc_dout_a), .adc_dout_b(adc_dout_b),
        .res_valid(res_valid), .res_word_a(res_word_a), .res_word_b(res_word_b),
        .res_twos(res_twos)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic logic exp_twos_code(req_t r);
        return r.wide || (!r.single && !r.addr[0]);
    endfunction

    function automatic logic [W-1:0] exp_word(req_t r, logic [W-1:0] raw);
        if (exp_twos_code(r) && r.off) return raw ^ 12'h800;
        return raw;
    endfunction

    function automatic int max3(int a, int b, int c);
        int m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    req_t frameq[$];
    res_t resq[$];
    req_t drv_req;
    req_t cur;
    res_t cur_res;

    logic p_cs = 1'b1, p_sclk = 1'b1, p_rst = 1'b0, p_valid = 1'b0;
    logic [4:0] p_lines = '0;
    logic [4:0] snap_lines = '0;
    int rises = 0, falls = 0, last_edge = 0;
    int last_restart = -1000, last_accept = -1000, last_end = -1000;
    int frame_idx = 0;
    bit bad_ready = 0, bad_idle = 0;

    // Converter model and port monitor, sampled mid-cycle
    always @(negedge clk) begin
        logic [4:0] lines;
        logic rise, fall;
        lines = {adc_addr, adc_single, adc_wide};
        if (!rst_n) begin
            p_cs = 1'b1; p_sclk = 1'b1; p_lines = '0; p_rst = 1'b0; p_valid = 1'b0;
        end else begin
            if (!p_rst) last_restart = cyc;
            if (lines != p_lines) last_restart = cyc;
            if (adc_cs_n && !adc_sclk) bad_idle = 1;
            rise = adc_sclk && !p_sclk && !p_cs;
            fall = !adc_sclk && p_sclk && !p_cs;

            if (!adc_cs_n && p_cs) begin
                int expf;
                expf = max3(last_restart + ACQ + 1, last_accept + 2, last_end + 1);
                check(cyc == expf, "R8 R11 frame start cycle", cyc, expf);
                if (frameq.size() == 0) begin
                    check(0, "R4 frame without request", 0, 1);
                end else begin
                    cur = frameq.pop_front();
                    check(lines == {cur.addr, cur.single, cur.wide}, "R5 control lines",
                          lines, {cur.addr, cur.single, cur.wide});
                    cur_res.r = cur;
                    if (frame_idx == 0)      begin cur_res.a = 12'hFFF; cur_res.b = 12'h000; end
                    else if (frame_idx == 1) begin cur_res.a = 12'h800; cur_res.b = 12'h7FF; end
                    else begin cur_res.a = W'($urandom); cur_res.b = W'($urandom); end
                    resq.push_back(cur_res);
                end
                frame_idx++;
                snap_lines = lines;
                rises = 0; falls = 0; bad_ready = 0; last_edge = cyc;
            end

            if (rise || fall) begin
                check(cyc - last_edge == DIV, "R2 sclk phase length", cyc - last_edge, DIV);
                last_edge = cyc;
            end

            if (fall) begin
                falls++;
                if (falls >= 3 && falls <= TRACK) begin
                    adc_dout_a = cur_res.a[TRACK - falls];
                    adc_dout_b = cur_res.b[TRACK - falls];
                end else begin
                    // R3: bits outside the result field carry the opposite of the MSB
                    adc_dout_a = ~cur_res.a[W-1];
                    adc_dout_b = ~cur_res.b[W-1];
                end
            end

            if (rise) begin
                rises++;
                if (rises == TRACK) begin
                    check(lines == snap_lines, "R6 lines held through tracking edge", lines, snap_lines);
                    check(!bad_ready, "R7 ready low before tracking edge", bad_ready, 0);
                    check(res_valid == 1'b1, "R4 result at tracking edge", res_valid, 1);
                    last_restart = cyc;
                end
                if (rises == FRAME) begin
                    check(adc_cs_n == 1'b1, "R2 frame ends at 16th rise", adc_cs_n, 1);
                    last_end = cyc;
                end
            end

            if (!adc_cs_n && rises < TRACK && req_ready) bad_ready = 1;

            if (res_valid) begin
                check(!p_valid, "R4 single cycle valid", p_valid, 0);
                if (resq.size() == 0) begin
                    check(0, "R4 unexpected result", 1, 0);
                end else begin
                    res_t e;
                    e = resq.pop_front();
                    check(res_word_a == exp_word(e.r, e.a), "R3 R10 word A", res_word_a, exp_word(e.r, e.a));
                    check(res_word_b == exp_word(e.r, e.b), "R3 R10 word B", res_word_b, exp_word(e.r, e.b));
                    check(res_twos == (exp_twos_code(e.r) && !e.r.off), "R9 R10 coding flag",
                          res_twos, exp_twos_code(e.r) && !e.r.off);
                end
            end

            if (req_valid && req_ready) begin
                last_accept = cyc;
                frameq.push_back(drv_req);
            end

            p_cs = adc_cs_n; p_sclk = adc_sclk; p_lines = lines;
            p_valid = res_valid; p_rst = 1'b1;
        end
    end

    task automatic send(input logic [2:0] a, input logic s, input logic w, input logic o);
        @(posedge clk); #5;
        drv_req.addr = a; drv_req.single = s; drv_req.wide = w; drv_req.off = o;
        req_addr = a; req_single = s; req_wide = w; req_offset = o;
        req_valid = 1'b1;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        @(posedge clk); #5;
        req_valid = 1'b0;
        req_addr = ~a; req_single = ~s; req_wide = ~w;
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        // R1 reset state
        check(adc_cs_n == 1'b1 && adc_sclk == 1'b1, "R1 cs/sclk in reset", {adc_cs_n, adc_sclk}, 3);
        check({adc_addr, adc_single, adc_wide} == 5'd0, "R1 lines in reset",
              {adc_addr, adc_single, adc_wide}, 0);
        check(res_valid == 1'b0, "R1 no result in reset", res_valid, 0);
        @(posedge clk); #5 rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);

        // directed corners
        send(3'd0, 1'b1, 1'b0, 1'b0);   // R9 single-ended narrow: straight
        send(3'd5, 1'b1, 1'b1, 1'b0);   // R9 single-ended wide: twos
        send(3'd0, 1'b0, 1'b0, 1'b1);   // R10 fully differential with offset
        send(3'd1, 1'b0, 1'b0, 1'b1);   // R10 pseudo narrow: offset has no effect
        send(3'd3, 1'b0, 1'b1, 1'b1);   // R10 pseudo wide with offset
        send(3'd3, 1'b0, 1'b1, 1'b1);   // R11 same lines again
        send(3'd4, 1'b0, 1'b1, 1'b0);   // mode held, address changes
        repeat (300) @(posedge clk);
        send(3'd4, 1'b0, 1'b1, 1'b0);   // R11 idle repeat, no new wait

        for (int i = 0; i < 40; i++) begin
            logic s;
            logic [2:0] a;
            s = 1'($urandom);
            if (s) a = 3'($urandom_range(0, 5));
            else   a = {2'($urandom_range(0, 2)), 1'($urandom)};
            send(a, s, 1'($urandom), 1'($urandom));
            if ($urandom_range(0, 7) == 0) repeat ($urandom_range(1, 150)) @(posedge clk);
        end

        repeat (400) @(posedge clk);
        check(frameq.size() == 0 && resq.size() == 0, "R4 every request answered",
              frameq.size() + resq.size(), 0);
        check(!bad_idle, "R2 sclk high while deselected", bad_idle, 0);
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        check(0, "watchdog expired", 0, 1);
        finish_run();
    end

endmodule